// File: doc/BRIEF.md
# Circular Trace Buffer Write Engine

This block takes a byte stream from a trace source, packs the bytes into aligned words and writes them to a memory region. Software describes the region with three byte addresses: a start address (base), a current write address and an end address (limit). Words go out one at a time over a valid/ready write port, moving upward from the write address. When a word lands in the last slot below the limit, the write address returns to the base. This is a wrap event. It sets the wrap flag and raises a level interrupt.

Two capture modes decide what happens after a wrap. In fill mode, capture stops and the block waits for software to clear the status, reprogram the pointers and enable it again. In wrap mode, capture goes on from the base. A trigger input can stop capture, flag it or be ignored, as a control field selects. A memory error response stops capture with a fatal error class. Bytes that arrive while capture is off are dropped and counted. A drain request pads out any partial word and flushes it, and the idle output then reports that nothing is held inside the block.

Top module: `trc_ring_writer`

## Requirements
- R1: After reset all registers read zero, the interrupt output is low, the memory port is not valid, `idle` is high and the drop counter is zero.
- R2: Accepted bytes are packed little-endian, with the first byte in bits 7:0, into words of WB bytes. Each word is written at the current write address, which then advances by WB once the word is accepted.
- R3: Writes to the base register (address 0) and to the limit field clear the address bits below the page size. Writes to the write-pointer register (address 1) clear the bits below the word size. The limit register (address 2) holds enable in bit 0, fill mode in bit 1 and trigger mode in bits 4:3, and these bits read back as written.
- R4: In fill mode, when the accepted word's next address equals the limit, the write pointer returns to base, capture stops and the status register (address 3) reads 0x10D. The status fields are: pending bit 0, trigger bit 1, wrap bit 2, stopped bit 3, error class bits 7:4, buffer code bits 15:8, and code 1 means filled.
- R5: In wrap mode, the same event returns the pointer to base, sets wrap and pending (status 0x005), and capture continues at base.
- R6: An enable is refused unless base <= write pointer < limit. A refused enable leaves the block stopped with error class 3, so the status reads 0x038, and it takes no bytes.
- R7: A trigger pulse with trigger mode 3 has no effect. Modes 1 and 2 set the trigger and pending bits and keep capturing (status 0x003). Mode 0 stops capture with buffer code 2 (status 0x20B).
- R8: While stopped or disabled, `trc_ready` is low, the block writes nothing, and each offered byte increments the drop counter (address 5). The counter saturates at its maximum.
- R9: A word accepted with `mem_resp` 1 or 2 stops capture with pending set and error class 1 or 2 (status 0x019 or 0x029), and the write pointer does not move.
- R10: While `drain_req` is high, no byte is taken. A partial word is completed with the pad byte (0x00 by default) and written, and `idle` then rises.
- R11: `mem_valid`, `mem_addr` and `mem_data` hold steady until `mem_ready`. Bytes are still taken while a word waits.
- R12: The interrupt output stays high until software writes the pending bit to zero. Writing zero to the limit register disables capture.
- R13: The identification register (address 4) reads log2(WB) in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| trc_valid | input | 1 | Trace byte offered |
| trc_byte | input | 8 | Trace byte |
| trc_ready | output | 1 | Byte taken this cycle |
| trig | input | 1 | Trigger event pulse |
| drain_req | input | 1 | Request to flush held trace |
| idle | output | 1 | No byte or word held inside |
| mem_valid | output | 1 | Word write request |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | AW | Byte address of the word |
| mem_data | output | 8*WB | Word data |
| mem_resp | input | 2 | Response with ready: 0 ok, 1 stage-1 abort, 2 stage-2 abort |
| irq | output | 1 | Maintenance interrupt, level |

## Verification
The bench builds the block with AW=12, WB=4, a 64-byte page (PAGE_LG=6) and a 4-bit drop counter. The region is then 16 words long, so every start slot from base to limit-4 can be swept in fill mode, and wrap mode can go around the region with a stalling memory. The short counter lets the bench reach drop-count saturation in a few pulses. It also makes room to cover every trigger mode, both abort classes, pointer refusal and a padded drain.

// File: rtl/trc_ring_pkg.sv
package trc_ring_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] REG_BASE  = 3'd0;
  localparam logic [2:0] REG_WPTR  = 3'd1;
  localparam logic [2:0] REG_LIMIT = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;
  localparam logic [2:0] REG_IDENT = 3'd4;
  localparam logic [2:0] REG_DROPS = 3'd5;

  localparam logic [3:0] EC_OTHER   = 4'd0;
  localparam logic [3:0] EC_S1      = 4'd1;
  localparam logic [3:0] EC_S2      = 4'd2;
  localparam logic [3:0] EC_BAD_PTR = 4'd3;

  localparam logic [7:0] BC_NONE  = 8'd0;
  localparam logic [7:0] BC_FILL  = 8'd1;
  localparam logic [7:0] BC_TRIG  = 8'd2;

  localparam logic [1:0] TM_STOP   = 2'b00;
  localparam logic [1:0] TM_IGNORE = 2'b11;

  typedef struct packed {
    logic [7:0] code;
    logic [3:0] ecls;
    logic       stop;
    logic       wrap;
    logic       trg;
    logic       pend;
  } stat_t;
endpackage

// File: rtl/trc_byte_packer.sv
module trc_byte_packer #(
  parameter int WB = 4,
  parameter logic [7:0] PAD = 8'h00,
  localparam int CW = $clog2(WB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pad_req,
  input  logic          pop,
  output logic          full,
  output logic          busy,
  output logic [8*WB-1:0] word
);
  logic [CW-1:0] cnt_q;
  logic          pad_go;

  assign full   = (cnt_q == CW'(WB));
  assign busy   = (cnt_q != '0);
  assign pad_go = pad_req && busy && !full;

  always_ff @(posedge clk) begin
    if (rst || flush)  cnt_q <= '0;
    else if (pop)      cnt_q <= '0;
    else if (pad_go)   cnt_q <= CW'(WB);
    else if (push)     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < WB; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (push && cnt_q == CW'(g))       lane_q <= din;
      else if (pad_go && cnt_q <= CW'(g)) lane_q <= PAD;
    end
    assign word[g*8 +: 8] = lane_q;
  end

  a_r2_pop_clears: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush) |=> (cnt_q == '0));
  a_r2_push_steps: assert property (@(posedge clk) disable iff (rst)
    (push && !flush && !pop && !pad_go && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/trc_drop_ctr.sv
module trc_drop_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (hit && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end
  assign count = cnt_q;

  a_r8_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) |=> (cnt_q == TOP));
endmodule

// File: rtl/trc_ring_writer.sv
module trc_ring_writer
  import trc_ring_pkg::*;
#(
  parameter int AW = 16,
  parameter int WB = 4,
  parameter int PAGE_LG = 12,
  parameter int DROP_W = 8,
  parameter logic [7:0] PAD_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              trc_valid,
  input  logic [7:0]        trc_byte,
  output logic              trc_ready,
  input  logic              trig,
  input  logic              drain_req,
  output logic              idle,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [8*WB-1:0]   mem_data,
  input  logic [1:0]        mem_resp,
  output logic              irq
);
  localparam int WB_LG = $clog2(WB);
  localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_LG;
  localparam logic [AW-1:0] WORD_MASK = {AW{1'b1}} << WB_LG;

  logic [AW-1:0] base_q, wptr_q, wptr_d, lim_q, out_addr_q;
  logic          en_q, en_d, fill_q, out_valid_q;
  logic [1:0]    tmode_q;
  stat_t         stat_q, stat_d;
  logic [8*WB-1:0] out_data_q, pack_word;
  logic [REG_W-1:0] rdata_q, rd_mux;
  logic [DROP_W-1:0] drop_cnt;
  logic pack_full, pack_busy, running, launch, accept, push, hit_lim, start_ok;
  logic wr_base, wr_wptr, wr_lim, wr_stat, trig_live;
  logic [AW-1:0] lim_new, nxt_addr;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_base = reg_we && reg_addr == REG_BASE;
  assign wr_wptr = reg_we && reg_addr == REG_WPTR;
  assign wr_lim  = reg_we && reg_addr == REG_LIMIT;
  assign wr_stat = reg_we && reg_addr == REG_STAT;

  assign running   = en_q && !stat_q.stop;
  assign lim_new   = reg_wdata[AW-1:0] & PAGE_MASK;
  assign start_ok  = (base_q <= wptr_q) && (wptr_q < lim_new);
  assign accept    = out_valid_q && mem_ready;
  assign nxt_addr  = out_addr_q + AW'(WB);
  assign hit_lim   = (nxt_addr == lim_q);
  assign trig_live = running && trig;
  assign trc_ready = running && !drain_req && !pack_full;
  assign push      = trc_valid && trc_ready;
  assign launch    = running && pack_full && !out_valid_q;

  trc_byte_packer #(.WB(WB), .PAD(PAD_BYTE)) i_pack (
    .clk(clk), .rst(rst), .flush(!running), .push(push), .din(trc_byte),
    .pad_req(drain_req && running), .pop(launch),
    .full(pack_full), .busy(pack_busy), .word(pack_word)
  );

  trc_drop_ctr #(.W(DROP_W)) i_drops (
    .clk(clk), .rst(rst), .hit(trc_valid && !running), .count(drop_cnt)
  );

  // Next state of pointer, enable and status: register writes first, engine events last.
  always_comb begin
    stat_d = stat_q;
    wptr_d = wptr_q;
    en_d   = en_q;
    if (wr_stat) stat_d = stat_t'(reg_wdata[15:0]);
    if (wr_wptr) wptr_d = reg_wdata[AW-1:0] & WORD_MASK;
    if (wr_lim) begin
      if (!reg_wdata[0]) en_d = 1'b0;
      else if (start_ok) en_d = 1'b1;
      else begin
        en_d        = 1'b0;
        stat_d.stop = 1'b1;
        stat_d.ecls = EC_BAD_PTR;
      end
    end
    if (trig_live && tmode_q != TM_IGNORE) begin
      stat_d.trg  = 1'b1;
      stat_d.pend = 1'b1;
      if (tmode_q == TM_STOP) begin
        stat_d.stop = 1'b1;
        stat_d.ecls = EC_OTHER;
        stat_d.code = BC_TRIG;
        en_d        = 1'b0;
      end
    end
    if (accept) begin
      if (mem_resp != 2'b00) begin
        stat_d.stop = 1'b1;
        stat_d.pend = 1'b1;
        stat_d.ecls = (mem_resp == 2'b01) ? EC_S1 : EC_S2;
        en_d        = 1'b0;
      end else if (hit_lim) begin
        wptr_d      = base_q;
        stat_d.wrap = 1'b1;
        stat_d.pend = 1'b1;
        if (fill_q) begin
          stat_d.stop = 1'b1;
          stat_d.ecls = EC_OTHER;
          stat_d.code = BC_FILL;
          en_d        = 1'b0;
        end
      end else begin
        wptr_d = nxt_addr;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_BASE:  rd_mux[AW-1:0] = base_q;
      REG_WPTR:  rd_mux[AW-1:0] = wptr_q;
      REG_LIMIT: begin
        rd_mux[AW-1:0] = lim_q;
        rd_mux[0]      = en_q;
        rd_mux[1]      = fill_q;
        rd_mux[4:3]    = tmode_q;
      end
      REG_STAT:  rd_mux[15:0] = stat_q;
      REG_IDENT: rd_mux[3:0]  = 4'(WB_LG);
      REG_DROPS: rd_mux[DROP_W-1:0] = drop_cnt;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q      <= '0;
      wptr_q      <= '0;
      lim_q       <= '0;
      en_q        <= 1'b0;
      fill_q      <= 1'b0;
      tmode_q     <= TM_STOP;
      stat_q      <= '0;
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
      rdata_q     <= '0;
    end else begin
      wptr_q  <= wptr_d;
      en_q    <= en_d;
      stat_q  <= stat_d;
      rdata_q <= rd_mux;
      if (wr_base) base_q <= reg_wdata[AW-1:0] & PAGE_MASK;
      if (wr_lim) begin
        lim_q   <= lim_new;
        fill_q  <= reg_wdata[1];
        tmode_q <= reg_wdata[4:3];
      end
      if (launch) begin
        out_valid_q <= 1'b1;
        out_addr_q  <= wptr_q;
      end else if (accept) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (launch) out_data_q <= pack_word;
  end

  assign reg_rdata = rdata_q;
  assign mem_valid = out_valid_q;
  assign mem_addr  = out_addr_q;
  assign mem_data  = out_data_q;
  assign irq       = stat_q.pend;
  assign idle      = !out_valid_q && !pack_busy;

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  a_r4_fill_stop: assert property (@(posedge clk) disable iff (rst)
    (accept && mem_resp == 2'b00 && hit_lim && fill_q) |=> (stat_q.stop && wptr_q == $past(base_q)));
  a_r9_abort_ptr: assert property (@(posedge clk) disable iff (rst)
    (accept && mem_resp != 2'b00 && !wr_wptr) |=> $stable(wptr_q));
  a_r6_refuse: assert property (@(posedge clk) disable iff (rst)
    (wr_lim && reg_wdata[0] && !start_ok) |=> !running);
endmodule

// File: tb/test_trc_ring_writer.sv
module test_trc_ring_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WB = 4;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] LIM  = 32'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic trc_valid = 1'b0, trc_ready, trig = 1'b0, drain_req = 1'b0, idle;
  logic [7:0] trc_byte = '0;
  logic mem_valid, mem_ready = 1'b0, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;
  logic [1:0] mem_resp = 2'b00;
  logic [1:0] resp_cfg = 2'b00;
  logic stall = 1'b0;
  int cyc = 0, n_cmp = 0, n_bad = 0, strm = 0;
  bit done = 0;
  logic [31:0] mem_m [0:1023];
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_ring_writer #(.AW(AW), .WB(WB), .PAGE_LG(6), .DROP_W(4)) i_trc_ring_writer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trc_valid(trc_valid), .trc_byte(trc_byte), .trc_ready(trc_ready),
    .trig(trig), .drain_req(drain_req), .idle(idle), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_resp(mem_resp),
    .irq(irq));

  // Memory model: pick ready first, then record the word that will be accepted.
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
    mem_resp  = resp_cfg;
    if (mem_valid && mem_ready && resp_cfg == 2'b00) mem_m[mem_addr[AW-1:2]] = mem_data;
  end

  function automatic logic [7:0] fb(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction
  function automatic logic [31:0] fw(input int j);
    return {fb(4*j+3), fb(4*j+2), fb(4*j+1), fb(4*j)};
  endfunction
  function automatic logic [31:0] sent(input int i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 1024; i++) mem_m[i] = sent(i);
  endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask
  task automatic send(input logic [7:0] b);
    trc_valid = 1'b1; trc_byte = b;
    while (!trc_ready) @(negedge clk);
    @(negedge clk);
    trc_valid = 1'b0;
  endtask
  task automatic send_words(input int n);
    for (int k = 0; k < 4*n; k++) begin
      send(fb(strm*4 + k));
    end
    strm = strm + n;
  endtask
  task automatic drop_pulse();
    trc_valid = 1'b1; trc_byte = 8'h5A;
    @(negedge clk);
    trc_valid = 1'b0;
  endtask
  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400 && !idle; i++) @(negedge clk);
  endtask
  task automatic arm(input logic [31:0] wp, input logic [31:0] ctl);
    wr(3'd3, 32'h0);
    wr(3'd0, BASE);
    wr(3'd1, wp);
    wr(3'd2, LIM | ctl);
    strm = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    clr_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 idle", {31'b0, idle}, 32'd1);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), rv); chk("R1 reg", rv, 32'd0);
    end
    rd(3'd5, rv); chk("R1 drops", rv, 32'd0);
    // R13 identification
    rd(3'd4, rv); chk("R13 ident", rv, 32'd2);

    // R8 drops while disabled, then saturation
    for (int i = 0; i < 5; i++) drop_pulse();
    rd(3'd5, rv); chk("R8 drop count", rv, 32'd5);
    for (int i = 0; i < 12; i++) drop_pulse();
    rd(3'd5, rv); chk("R8 drop saturate", rv, 32'd15);

    // R3 alignment masking and control field readback
    wr(3'd0, 32'h47); rd(3'd0, rv); chk("R3 base mask", rv, 32'h40);
    wr(3'd1, 32'h4B); rd(3'd1, rv); chk("R3 wptr mask", rv, 32'h48);
    wr(3'd2, 32'hBE); rd(3'd2, rv); chk("R3 limit fields", rv, 32'h9A);

    // R2 R4 fill-mode sweep over every start slot
    for (int s = 0; s < 16; s++) begin
      clr_mem();
      arm(BASE + 32'(4*s), 32'h1B);
      send_words(16 - s);
      wait_idle();
      for (int j = 0; j < 16; j++) begin
        if (j >= s) chk("R2 fill word", mem_m[16+j], fw(j - s));
        else        chk("R2 untouched", mem_m[16+j], sent(16+j));
      end
      chk("R4 past limit", mem_m[32], sent(32));
      rd(3'd3, rv); chk("R4 fill status", rv, 32'h10D);
      rd(3'd1, rv); chk("R4 ptr at base", rv, BASE);
      chk("R12 irq held", {31'b0, irq}, 32'd1);
      chk("R8 not ready when stopped", {31'b0, trc_ready}, 32'd0);
    end
    wr(3'd3, 32'h0);
    chk("R12 irq cleared", {31'b0, irq}, 32'd0);

    // R5 R11 wrap mode with a stalling memory
    clr_mem();
    stall = 1'b1;
    arm(BASE + 32'd20, 32'h19);
    send_words(18);
    wait_idle();
    stall = 1'b0;
    for (int j = 0; j < 16; j++)
      chk("R5 wrap word", mem_m[16+j], (j < 7) ? fw(11 + j) : fw(j - 5));
    rd(3'd3, rv); chk("R5 wrap status", rv, 32'h005);
    rd(3'd1, rv); chk("R5 ptr continues", rv, BASE + 32'd28);

    // R6 refused enables
    arm(LIM, 32'h19);
    rd(3'd3, rv); chk("R6 wptr at limit", rv, 32'h038);
    chk("R6 no bytes", {31'b0, trc_ready}, 32'd0);
    arm(32'h3C, 32'h19);
    rd(3'd3, rv); chk("R6 wptr below base", rv, 32'h038);

    // R7 trigger modes
    clr_mem();
    arm(BASE, 32'h19);
    send_words(1); pulse_trig(); wait_idle();
    rd(3'd3, rv); chk("R7 ignore", rv, 32'h000);
    wr(3'd2, LIM | 32'h09);
    pulse_trig();
    send_words(1); wait_idle();
    rd(3'd3, rv); chk("R7 note status", rv, 32'h003);
    rd(3'd1, rv); chk("R7 note continues", rv, BASE + 32'd8);
    chk("R7 note data", mem_m[17], fw(1));
    wr(3'd3, 32'h0);
    wr(3'd2, LIM | 32'h01);
    pulse_trig();
    rd(3'd3, rv); chk("R7 stop status", rv, 32'h20B);
    for (int i = 0; i < 6; i++) drop_pulse();
    wait_idle();
    rd(3'd1, rv); chk("R8 ptr unchanged", rv, BASE + 32'd8);
    chk("R8 no write", mem_m[18], sent(18));

    // R9 abort classes
    arm(BASE + 32'd12, 32'h19);
    resp_cfg = 2'b01;
    send_words(1); wait_idle();
    resp_cfg = 2'b00;
    rd(3'd3, rv); chk("R9 stage1", rv, 32'h019);
    rd(3'd1, rv); chk("R9 ptr kept", rv, BASE + 32'd12);
    arm(BASE + 32'd12, 32'h19);
    resp_cfg = 2'b10;
    send_words(1); wait_idle();
    resp_cfg = 2'b00;
    rd(3'd3, rv); chk("R9 stage2", rv, 32'h029);

    // R10 drain pads a partial word
    clr_mem();
    arm(BASE + 32'd16, 32'h19);
    send(fb(0)); send(fb(1));
    drain_req = 1'b1;
    @(negedge clk);
    chk("R10 no take in drain", {31'b0, trc_ready}, 32'd0);
    wait_idle();
    drain_req = 1'b0;
    chk("R10 idle", {31'b0, idle}, 32'd1);
    chk("R10 padded word", mem_m[20], {8'h00, 8'h00, fb(1), fb(0)});
    rd(3'd1, rv); chk("R10 ptr", rv, BASE + 32'd20);

    // R12 disable by writing zero to the limit register
    wr(3'd2, 32'h0);
    rd(3'd2, rv); chk("R12 limit zero", rv, 32'h0);
    for (int i = 0; i < 4; i++) drop_pulse();
    wait_idle();
    chk("R12 no write", mem_m[21], sent(21));
    rd(3'd1, rv); chk("R12 ptr kept", rv, BASE + 32'd20);

    finish_run();
  end
endmodule